// File: doc/BRIEF.md
# Matrix Keypad Row Scanner

This block scans an 8 by 8 key matrix without software help. It drives a single active-high select onto one of the eight row lines at a time and reads the eight column lines back. Each row is held for a programmable number of settle cycles. At the end of that window the columns are sampled. If no column is active the select moves on to the next row. After the last row it returns to the first.

When a sampled row shows any active column, the block raises a one-clock valid pulse. With the pulse it reports the row number, the lowest active column number and the linear key index row*8+column. It also gives a table offset, which is the index shifted left by a parameterised amount: one for tables of 16-bit entries, zero for byte tables. The select then stays parked on that row until all columns read zero again. Scanning then restarts from the first row.

Top module: `kpad_scanner`

## Requirements
- R1: While reset is high, row_sel equals 8'h01 and key_valid is 0.
- R2: row_sel is always one-hot. Each row stays selected for SETTLE clock cycles. A row whose sampled columns are all zero is followed by the next row, and row_sel shifts left by one bit.
- R3: When row 7 (row_sel 8'h80) is sampled with no active column, row_sel returns to 8'h01.
- R4: When the sampled columns of row r are non-zero, key_valid is high for exactly one cycle. It is counted SETTLE*(r+1) rising edges after reset is released or after the scan restarts. Rows are scanned from 0 upward, so the lowest pressed row is found first.
- R5: key_col is the lowest-numbered active column in the sampled row (bit c of col_in is column c).
- R6: key_row is the number of the selected row (bit r of row_sel is row r) and is valid with key_valid.
- R7: key_index equals key_row*8 + key_col.
- R8: key_offset equals key_index shifted left by OFFSET_SHIFT; the default of 1 gives twice the index.
- R9: While the columns of the found row stay non-zero, row_sel does not move and key_valid stays 0.
- R10: On the first rising edge at which the held row's columns read all zero, row_sel returns to 8'h01 and a new scan begins.
- R11: An all-zero column reading never produces key_valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| col_in | input | COLS | Column readback, active high, synchronous to clk |
| row_sel | output | ROWS | One-hot active-high row drive |
| key_valid | output | 1 | One-cycle pulse when a key is found |
| key_row | output | $clog2(ROWS) | Row number of the found key |
| key_col | output | $clog2(COLS) | Lowest active column number |
| key_index | output | $clog2(ROWS*COLS) | row*COLS + column |
| key_offset | output | $clog2(ROWS*COLS)+OFFSET_SHIFT | Index shifted left by OFFSET_SHIFT |

## Verification
The sample of row r falls on rising edge SETTLE*(r+1), counted from reset release or from the restart edge. The key outputs are registered on that same edge, so the bench counts edges from that point. It expects key_valid and all four key fields on exactly that count and requires key_valid to be low one edge later. The return of row_sel to the first row is due on the single edge that sees the columns clear. The walking pattern is due at row floor(n/SETTLE) mod 8 after edge n. Every sample is taken one nanosecond after the rising edge, once the registers have settled and before the next edge.

// File: rtl/kpad_pkg.sv
package kpad_pkg;
  typedef enum logic {
    SCAN_SETTLE = 1'b0,
    SCAN_HOLD   = 1'b1
  } scan_st_e;
endpackage

// File: rtl/kpad_row_walker.sv
module kpad_row_walker #(
  parameter int ROWS   = 8,
  parameter int SETTLE = 4
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     col_any,
  output logic [$clog2(ROWS)-1:0]  row_idx,
  output logic [ROWS-1:0]          row_sel,
  output logic                     hit
);
  import kpad_pkg::*;

  localparam int ROW_W = $clog2(ROWS);
  localparam int CNT_W = (SETTLE > 1) ? $clog2(SETTLE) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(SETTLE - 1);
  localparam logic [ROW_W-1:0] ROW_LAST = ROW_W'(ROWS - 1);

  scan_st_e         st;
  logic [CNT_W-1:0] cnt;
  logic             at_sample;

  assign at_sample = (st == SCAN_SETTLE) && (cnt == CNT_LAST);
  assign hit       = at_sample && col_any;

  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= SCAN_SETTLE;
      cnt     <= '0;
      row_idx <= '0;
      row_sel <= ROWS'(1);
    end else begin
      case (st)
        SCAN_SETTLE: begin
          if (at_sample) begin
            cnt <= '0;
            if (col_any) begin
              st <= SCAN_HOLD;
            end else if (row_idx == ROW_LAST) begin
              row_idx <= '0;
              row_sel <= ROWS'(1);
            end else begin
              row_idx <= row_idx + 1'b1;
              row_sel <= row_sel << 1;
            end
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        SCAN_HOLD: begin
          if (!col_any) begin
            st      <= SCAN_SETTLE;
            cnt     <= '0;
            row_idx <= '0;
            row_sel <= ROWS'(1);
          end
        end
        default: st <= SCAN_SETTLE;
      endcase
    end
  end
endmodule

// File: rtl/kpad_col_encoder.sv
module kpad_col_encoder #(
  parameter int COLS = 8
) (
  input  logic [COLS-1:0]          cols,
  output logic                     any,
  output logic [$clog2(COLS)-1:0]  col_idx
);
  localparam int COL_W = $clog2(COLS);

  assign any = |cols;

  always_comb begin
    col_idx = '0;
    for (int c = COLS - 1; c >= 0; c--) begin
      if (cols[c]) col_idx = COL_W'(c);
    end
  end
endmodule

// File: rtl/kpad_index_former.sv
module kpad_index_former #(
  parameter int ROWS         = 8,
  parameter int COLS         = 8,
  parameter int OFFSET_SHIFT = 1
) (
  input  logic [$clog2(ROWS)-1:0]                     row,
  input  logic [$clog2(COLS)-1:0]                     col,
  output logic [$clog2(ROWS*COLS)-1:0]                index,
  output logic [$clog2(ROWS*COLS)+OFFSET_SHIFT-1:0]   offset
);
  localparam int IDX_W = $clog2(ROWS * COLS);

  assign index = IDX_W'(row) * IDX_W'(COLS) + IDX_W'(col);

  generate
    if (OFFSET_SHIFT == 0) begin : g_byte
      assign offset = index;
    end else begin : g_wide
      assign offset = {index, {OFFSET_SHIFT{1'b0}}};
    end
  endgenerate
endmodule

// File: rtl/kpad_scanner.sv
module kpad_scanner #(
  parameter int ROWS         = 8,
  parameter int COLS         = 8,
  parameter int SETTLE       = 4,
  parameter int OFFSET_SHIFT = 1
) (
  input  logic                                        clk,
  input  logic                                        rst,
  input  logic [COLS-1:0]                             col_in,
  output logic [ROWS-1:0]                             row_sel,
  output logic                                        key_valid,
  output logic [$clog2(ROWS)-1:0]                     key_row,
  output logic [$clog2(COLS)-1:0]                     key_col,
  output logic [$clog2(ROWS*COLS)-1:0]                key_index,
  output logic [$clog2(ROWS*COLS)+OFFSET_SHIFT-1:0]   key_offset
);
  localparam int ROW_W = $clog2(ROWS);
  localparam int COL_W = $clog2(COLS);
  localparam int IDX_W = $clog2(ROWS * COLS);
  localparam int OFS_W = IDX_W + OFFSET_SHIFT;

  logic             col_any;
  logic [COL_W-1:0] col_idx;
  logic [ROW_W-1:0] row_idx;
  logic             hit;
  logic [IDX_W-1:0] idx_d;
  logic [OFS_W-1:0] ofs_d;

  kpad_col_encoder #(.COLS(COLS)) u_enc (
    .cols    (col_in),
    .any     (col_any),
    .col_idx (col_idx)
  );

  kpad_row_walker #(.ROWS(ROWS), .SETTLE(SETTLE)) u_walk (
    .clk     (clk),
    .rst     (rst),
    .col_any (col_any),
    .row_idx (row_idx),
    .row_sel (row_sel),
    .hit     (hit)
  );

  kpad_index_former #(.ROWS(ROWS), .COLS(COLS), .OFFSET_SHIFT(OFFSET_SHIFT)) u_idx (
    .row    (row_idx),
    .col    (col_idx),
    .index  (idx_d),
    .offset (ofs_d)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      key_valid  <= 1'b0;
      key_row    <= '0;
      key_col    <= '0;
      key_index  <= '0;
      key_offset <= '0;
    end else begin
      key_valid <= hit;
      if (hit) begin
        key_row    <= row_idx;
        key_col    <= col_idx;
        key_index  <= idx_d;
        key_offset <= ofs_d;
      end
    end
  end
endmodule

// File: rtl/kpad_scanner_chk.sv
module kpad_scanner_chk #(
  parameter int ROWS = 8,
  parameter int COLS = 8
) (
  input logic                          clk,
  input logic                          rst,
  input logic [COLS-1:0]               col_in,
  input logic [ROWS-1:0]               row_sel,
  input logic                          key_valid,
  input logic [$clog2(ROWS)-1:0]       key_row,
  input logic [$clog2(COLS)-1:0]       key_col,
  input logic [$clog2(ROWS*COLS)-1:0]  key_index
);
  localparam int IDX_W = $clog2(ROWS * COLS);

  logic [COLS-1:0] col_q;
  always_ff @(posedge clk) col_q <= col_in;

  // R2
  row_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    $countones(row_sel) == 1);

  // R3
  row_step_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(row_sel) |-> (row_sel == ($past(row_sel) << 1)) || (row_sel == ROWS'(1)));

  // R4
  valid_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    key_valid |=> !key_valid);

  // R11
  valid_needs_col_chk: assert property (@(posedge clk) disable iff (rst)
    key_valid |-> (col_q != '0));

  // R5
  lowest_col_chk: assert property (@(posedge clk) disable iff (rst)
    key_valid |-> col_q[key_col] && ((col_q & ((COLS'(1) << key_col) - 1'b1)) == '0));

  // R6
  row_match_chk: assert property (@(posedge clk) disable iff (rst)
    key_valid |-> row_sel[key_row]);

  // R7
  index_form_chk: assert property (@(posedge clk) disable iff (rst)
    key_valid |-> key_index == IDX_W'(key_row) * IDX_W'(COLS) + IDX_W'(key_col));
endmodule

bind kpad_scanner kpad_scanner_chk #(.ROWS(ROWS), .COLS(COLS)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .col_in    (col_in),
  .row_sel   (row_sel),
  .key_valid (key_valid),
  .key_row   (key_row),
  .key_col   (key_col),
  .key_index (key_index)
);

// File: tb/kpad_scanner_test.sv
`timescale 1ns/1ps
module kpad_scanner_test;
  localparam int ROWS   = 8;
  localparam int COLS   = 8;
  localparam int SETTLE = 4;

  // row in [10:8], column mask in [7:0]
  localparam logic [10:0] VEC [0:7] = '{
    {3'd0, 8'h01}, {3'd7, 8'h80}, {3'd3, 8'h0C}, {3'd5, 8'hFF},
    {3'd2, 8'hA0}, {3'd6, 8'h40}, {3'd1, 8'h12}, {3'd4, 8'h08}
  };

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] col_in;
  logic [7:0] row_sel;
  logic       key_valid;
  logic [2:0] key_row;
  logic [2:0] key_col;
  logic [5:0] key_index;
  logic [6:0] key_offset;
  logic [7:0] keymap [0:7];
  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  always_comb begin
    col_in = '0;
    for (int r = 0; r < 8; r++) if (row_sel[r]) col_in = col_in | keymap[r];
  end

  kpad_scanner #(.ROWS(ROWS), .COLS(COLS), .SETTLE(SETTLE)) uut (
    .clk(clk), .rst(rst), .col_in(col_in), .row_sel(row_sel),
    .key_valid(key_valid), .key_row(key_row), .key_col(key_col),
    .key_index(key_index), .key_offset(key_offset)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic clear_keys();
    for (int r = 0; r < 8; r++) keymap[r] = 8'h00;
  endtask

  task automatic do_reset();
    @(negedge clk) rst = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    chk("R1 row_sel in reset", row_sel, 1);
    chk("R1 key_valid in reset", key_valid, 0);
    @(negedge clk) rst = 1'b0;
  endtask

  task automatic wait_valid(output int cyc);
    cyc = 0;
    forever begin
      @(posedge clk);
      #1;
      cyc++;
      if (key_valid || cyc >= 200) break;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int cyc;
    int r;
    int c;
    clear_keys();

    // table walk: one pressed row per entry, scan from reset
    for (int i = 0; i < 8; i++) begin
      clear_keys();
      r = int'(VEC[i][10:8]);
      keymap[r] = VEC[i][7:0];
      c = -1;
      for (int b = 7; b >= 0; b--) if (VEC[i][b]) c = b;
      do_reset();
      wait_valid(cyc);
      chk("R4 valid edge count", cyc, (r + 1) * SETTLE);
      chk("R6 key_row", key_row, r);
      chk("R5 key_col lowest", key_col, c);
      chk("R7 key_index", key_index, r * 8 + c);
      chk("R8 key_offset", key_offset, (r * 8 + c) * 2);
      @(posedge clk); #1;
      chk("R4 one-cycle pulse", key_valid, 0);
    end

    // no key: walking pattern and wrap
    clear_keys();
    do_reset();
    for (int n = 1; n <= 8 * SETTLE * 2 + 3; n++) begin
      @(posedge clk); #1;
      if (n >= 8 * SETTLE) chk("R3 wrap row_sel", row_sel, 1 << ((n / SETTLE) % 8));
      else                 chk("R2 walk row_sel", row_sel, 1 << ((n / SETTLE) % 8));
      chk("R11 no key no valid", key_valid, 0);
    end

    // hold while pressed, restart after release
    clear_keys();
    keymap[3] = 8'h40;
    do_reset();
    wait_valid(cyc);
    chk("R4 row 3 edge count", cyc, 4 * SETTLE);
    chk("R5 key_col row 3", key_col, 6);
    for (int n = 0; n < 3 * SETTLE; n++) begin
      @(posedge clk); #1;
      chk("R9 held row_sel", row_sel, 8'h08);
      chk("R9 no repeat valid", key_valid, 0);
    end
    @(negedge clk) keymap[3] = 8'h00;
    @(posedge clk); #1;
    chk("R10 restart row_sel", row_sel, 1);
    keymap[2] = 8'h04;
    wait_valid(cyc);
    chk("R10 rescan edge count", cyc, 3 * SETTLE);
    chk("R6 rescan key_row", key_row, 2);
    chk("R5 rescan key_col", key_col, 2);

    // two rows pressed: lower row first, higher after release
    clear_keys();
    keymap[2] = 8'h01;
    keymap[5] = 8'h20;
    do_reset();
    wait_valid(cyc);
    chk("R4 lower row first count", cyc, 3 * SETTLE);
    chk("R6 lower row first", key_row, 2);
    @(negedge clk) keymap[2] = 8'h00;
    @(posedge clk); #1;
    chk("R10 restart after partial release", row_sel, 1);
    wait_valid(cyc);
    chk("R4 second row count", cyc, 6 * SETTLE);
    chk("R6 second row", key_row, 5);
    chk("R7 second index", key_index, 45);
    chk("R8 second offset", key_offset, 90);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule